// File: doc/BRIEF.md
# PCI Configuration Space Register File

This block holds the 256-byte configuration space of a single PCI function and serves byte, word and dword accesses at any byte offset. A request carries a 24-bit configuration address, a length of 1, 2 or 4 bytes and, for writes, the data. Read data comes back little-endian one cycle after the request.

Writes are filtered per byte by a writable map that depends on the header type. The header type is fixed by the `BRIDGE` parameter: 0x00 for an endpoint and 0x81 for a bridge. Aligned dword writes to a base address register or to the expansion ROM register are masked by the region size, so software can size regions by writing all ones. The ROM register keeps its enable bit.

A one-cycle remap strobe tells the surrounding address decoders to rebuild their windows. For a bridge, the secondary bus number is brought out as a port. The address front end compares the bus and device/function fields against the function's own position. It drops every access that does not match.

Top module: `cfg_space`

## Requirements
- R1: After reset, a bridge (`BRIDGE`=1) holds these values, with every other byte zero:
  - vendor ID `VENDOR_ID` at 0x00, little-endian;
  - device ID `DEVICE_ID` at 0x02;
  - command 0x06 at 0x04;
  - 0xA0 at 0x06;
  - class bytes 0x04 at 0x0A and 0x06 at 0x0B;
  - 0x10 at 0x0D;
  - 0x81 at 0x0E;
  - 0xA0 at 0x1E.

  `rd_data`, `remap_pulse` and `sec_bus` are zero after reset.
- R2: A read of length L (1, 2 or 4) at offset O returns byte O+k in bits 8k+7:8k for k<L, with the offset wrapping modulo 256. Bytes at k>=L read as zero.
- R3: Bytes 0x00–0x03, 0x08–0x0B and 0x0E are read-only; writes to them are dropped.
- R4: Outside the dword register path, each written byte lands only if its offset is writable:
  - endpoint: 0x04, 0x05, 0x0C, 0x0D, 0x3C and 0x40–0xFF;
  - bridge: the same offsets plus 0x18–0x1D, 0x20–0x2F, 0x3E and 0x3F.

  Bytes at index k>=L of the data are ignored.
- R5: A dword write at an offset aligned to 4 within the BAR area stores the data ANDed with ~(2^n−1), where n is the region's `BAR_LOG2` entry (n=0 stores zero). The BAR area is 0x10–0x17 for a bridge and 0x10–0x27 for an endpoint.
- R6: A dword write at the ROM offset stores the data ANDed with (~(2^`ROM_LOG2`−1) | 1). The ROM offset is 0x38 for a bridge and 0x30 for an endpoint.
- R7: `remap_pulse` is high for exactly the cycle after an accepted write whose bytes O..O+L−1 include 0x04 or 0x05, or after an accepted dword write taken by R5 or R6; otherwise it is low.
- R8: `sec_bus` equals byte 0x19. On a bridge it follows a byte write to 0x19 and a word or dword write starting at 0x18.
- R9: `req_addr` is split into three fields, and an access is accepted only when both bus and devfn match:
  - bits 23:16 are the bus, compared with `own_bus`;
  - bits 15:8 are the device/function (device in 15:11, function in 10:8), compared with `own_devfn`;
  - bits 7:0 are the offset.
- R10: A read that is not accepted returns 0xFFFFFFFF. A write that is not accepted changes no byte and raises no strobe.
- R11: `rd_data` changes only in the cycle after a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_bus | input | 8 | Bus number this function lives on |
| own_devfn | input | 8 | Device/function number of this function |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus, device/function and offset |
| req_len | input | 3 | Access length in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Read data, one cycle after a read |
| remap_pulse | output | 1 | One-cycle strobe: decode windows must be rebuilt |
| sec_bus | output | 8 | Secondary bus number (byte 0x19) |

## Verification
A single write can both raise the remap strobe and have part of its bytes dropped by the writable map. This happens when a word write at 0x03 touches the read-only last byte of the device ID and the command low byte. It also happens when a dword write at 0x04 reaches the read-only status bytes. The bench drives such straddling writes and then reads back the whole dword. It also compares the strobe in the following cycle against its own byte-by-byte model, so the dropped bytes and the strobe are judged from the same access.

// File: rtl/cfg_space.sv
module cfg_space #(
  parameter bit          BRIDGE     = 1'b1,
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h1234,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter int          BAR_LOG2 [6] = '{4, 12, 8, 0, 0, 0},
  parameter int          ROM_LOG2   = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  own_bus,
  input  logic [7:0]  own_devfn,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [23:0] req_addr,
  input  logic [2:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic [31:0] rd_data,
  output logic        remap_pulse,
  output logic [7:0]  sec_bus
);
  localparam int          NBAR    = BRIDGE ? 2 : 6;
  localparam logic [8:0]  BAR_END = 9'(16 + 4 * NBAR);
  localparam logic [7:0]  ROM_OFF = BRIDGE ? 8'h38 : 8'h30;
  localparam logic [7:0]  HDR     = BRIDGE ? 8'h81 : 8'h00;
  localparam logic [23:0] CLASS   = BRIDGE ? 24'h060400 : CLASS_CODE;

  logic [7:0] cfg [256];

  function automatic logic [31:0] size_mask(int l2);
    return (l2 == 0) ? 32'h0 : ~((32'h1 << l2) - 32'h1);
  endfunction

  function automatic logic writable(logic [7:0] a);
    if (a >= 8'h40 || a == 8'h04 || a == 8'h05 || a == 8'h0C || a == 8'h0D || a == 8'h3C)
      return 1'b1;
    if (BRIDGE)
      return (a >= 8'h18 && a <= 8'h1D) || (a >= 8'h20 && a <= 8'h2F) || a == 8'h3E || a == 8'h3F;
    return 1'b0;
  endfunction

  wire [7:0] off    = req_addr[7:0];
  wire       hit    = req_addr[23:16] == own_bus && req_addr[15:8] == own_devfn;
  wire       wr_acc = req_valid && req_write && hit;
  wire       is_bar = req_len == 3'd4 && off[1:0] == 2'b00 && off >= 8'h10 && {1'b0, off} < BAR_END;
  wire       is_rom = req_len == 3'd4 && off == ROM_OFF;
  wire [7:0] bidx   = (off - 8'h10) >> 2;

  logic [31:0] bmask, dword_val, rd_word;
  logic        cmd_touch;

  always_comb begin
    bmask = '0;
    for (int i = 0; i < 6; i++)
      if (bidx == 8'(i)) bmask = size_mask(BAR_LOG2[i]);
    dword_val = is_rom ? (req_wdata & (size_mask(ROM_LOG2) | 32'h1)) : (req_wdata & bmask);
  end

  always_comb begin
    cmd_touch = 1'b0;
    rd_word   = '0;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < req_len) begin
        if (off + 8'(k) == 8'h04 || off + 8'(k) == 8'h05) cmd_touch = 1'b1;
        rd_word[8*k +: 8] = cfg[off + 8'(k)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) cfg[i] <= '0;
      cfg[8'h00] <= VENDOR_ID[7:0];
      cfg[8'h01] <= VENDOR_ID[15:8];
      cfg[8'h02] <= DEVICE_ID[7:0];
      cfg[8'h03] <= DEVICE_ID[15:8];
      cfg[8'h09] <= CLASS[7:0];
      cfg[8'h0A] <= CLASS[15:8];
      cfg[8'h0B] <= CLASS[23:16];
      cfg[8'h0E] <= HDR;
      if (BRIDGE) begin
        cfg[8'h04] <= 8'h06;
        cfg[8'h06] <= 8'hA0;
        cfg[8'h0D] <= 8'h10;
        cfg[8'h1E] <= 8'hA0;
      end
      rd_data     <= '0;
      remap_pulse <= 1'b0;
    end else begin
      if (wr_acc) begin
        for (int k = 0; k < 4; k++) begin
          if (is_bar || is_rom)
            cfg[off + 8'(k)] <= dword_val[8*k +: 8];
          else if (3'(k) < req_len && writable(off + 8'(k)))
            cfg[off + 8'(k)] <= req_wdata[8*k +: 8];
        end
      end
      if (req_valid && !req_write) rd_data <= hit ? rd_word : 32'hFFFF_FFFF;
      remap_pulse <= wr_acc && (is_bar || is_rom || cmd_touch);
    end
  end

  assign sec_bus = cfg[8'h19];

  wire [31:0] bar0_word = {cfg[8'h13], cfg[8'h12], cfg[8'h11], cfg[8'h10]};
  wire [31:0] rom_word  = {cfg[ROM_OFF + 8'd3], cfg[ROM_OFF + 8'd2], cfg[ROM_OFF + 8'd1], cfg[ROM_OFF]};

  AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[8'h0E] == HDR && {cfg[8'h01], cfg[8'h00]} == VENDOR_ID); // R3
  AST_BAR0_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (bar0_word & ~size_mask(BAR_LOG2[0])) == 32'h0); // R5
  AST_ROM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_word & ~size_mask(ROM_LOG2) & ~32'h1) == 32'h0); // R6
  AST_REMAP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |-> $past(req_valid && req_write && hit)); // R7
  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write && !hit) |-> rd_data == 32'hFFFF_FFFF); // R10
  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && !req_write) |-> $stable(rd_data)); // R11
endmodule

// File: tb/cfg_space_bench.sv
`timescale 1ns/1ps
module cfg_space_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] own_bus = 8'h02, own_devfn = 8'h18;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [2:0] req_len = 3'd1;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic remap_pulse;
  logic [7:0] sec_bus;

  cfg_space u_cfg_space (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m [256];
  logic [31:0] e_rd = '0;
  bit e_remap = 1'b0;

  function automatic bit model_wr_ok(int a);
    if (a >= 64) return 1;
    if (a == 4 || a == 5 || a == 12 || a == 13 || a == 60 || a == 62 || a == 63) return 1;
    if (a >= 24 && a <= 29) return 1;
    if (a >= 32 && a <= 47) return 1;
    return 0;
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [7:0] bus, logic [7:0] devfn, int o, int len,
                      logic [31:0] d, string tag);
    req_valid = v; req_write = w; req_addr = {bus, devfn, 8'(o)};
    req_len = 3'(len); req_wdata = d;
    @(posedge clk);
    e_remap = 0;
    if (v && bus == own_bus && devfn == own_devfn) begin
      if (!w) begin
        e_rd = 0;
        for (int k = 0; k < len; k++) e_rd = e_rd | (32'(m[(o + k) % 256]) << (8 * k));
      end else if (len == 4 && o % 4 == 0 && ((o >= 16 && o < 24) || o == 56)) begin
        longint sz;
        logic [31:0] val;
        sz = (o == 56) ? 2048 : (o == 16 ? 16 : 4096);
        val = d & ~32'(sz - 1);
        if (o == 56) val = val | (d & 32'h1);
        for (int k = 0; k < 4; k++) m[o + k] = int'(val[8*k +: 8]);
        e_remap = 1;
      end else begin
        for (int k = 0; k < len; k++) begin
          int a;
          a = (o + k) % 256;
          if (a == 4 || a == 5) e_remap = 1;
          if (model_wr_ok(a)) m[a] = int'(d[8*k +: 8]);
        end
      end
    end else if (v && !w) e_rd = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 0;
    cmp({tag, " rd_data"}, rd_data, e_rd);
    cmp("R7 remap_pulse", 32'(remap_pulse), 32'(e_remap));
    cmp("R8 sec_bus", 32'(sec_bus), 32'(m[25]));
  endtask

  task automatic rd(int o, int len, string tag);
    step(1, 0, own_bus, own_devfn, o, len, 0, tag);
  endtask

  task automatic wr(int o, int len, logic [31:0] d, string tag);
    step(1, 1, own_bus, own_devfn, o, len, d, tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m[i] = 0;
    m[0] = 'hCD; m[1] = 'hAB; m[2] = 'h34; m[3] = 'h12; m[4] = 'h06; m[6] = 'hA0;
    m[10] = 'h04; m[11] = 'h06; m[13] = 'h10; m[14] = 'h81; m[30] = 'hA0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 reset rd_data", rd_data, 0);
    cmp("R1 reset remap", 32'(remap_pulse), 0);
    cmp("R1 reset sec_bus", 32'(sec_bus), 0);
    rd(0, 4, "R1 ids");
    cmp("R1 id dword", rd_data, 32'h1234ABCD);
    rd(8, 4, "R1 class");
    cmp("R1 class dword", rd_data, 32'h06040000);
    rd(12, 4, "R1 header");
    cmp("R1 header dword", rd_data, 32'h00811000);
    rd(4, 4, "R1 cmd/status");
    rd(28, 4, "R1 secondary status");
    rd(14, 1, "R2 byte read");
    cmp("R2 byte zero-extended", rd_data, 32'h00000081);
    rd(10, 2, "R2 word read");
    cmp("R2 word", rd_data, 32'h00000604);
    step(0, 0, own_bus, own_devfn, 0, 1, 0, "R11 idle hold");
    wr(0, 4, 32'hFFFFFFFF, "R3 write ids");
    rd(0, 4, "R3 ids kept");
    cmp("R3 ids unchanged", rd_data, 32'h1234ABCD);
    wr(12, 4, 32'hFFFFFFFF, "R4 header dword");
    rd(12, 4, "R4 header readback");
    cmp("R4 only 0C/0D written", rd_data, 32'h0081FFFF);
    wr(64, 1, 32'hFFFFFF5A, "R4 byte 0x40");
    wr(66, 2, 32'hFFFFBEEF, "R4 word 0x42");
    rd(64, 4, "R4 device area");
    cmp("R4 device area", rd_data, 32'hBEEF005A);
    wr(255, 2, 32'h00001177, "R2 wrap write");
    rd(255, 2, "R2 wrap read");
    wr(16, 4, 32'hFFFFFFFF, "R5 BAR0 probe");
    rd(16, 4, "R5 BAR0");
    cmp("R5 BAR0 sized", rd_data, 32'hFFFFFFF0);
    wr(20, 4, 32'hFFFFFFFF, "R5 BAR1 probe");
    rd(20, 4, "R5 BAR1");
    cmp("R5 BAR1 sized", rd_data, 32'hFFFFF000);
    wr(16, 1, 32'h0000007F, "R5 byte to BAR dropped");
    rd(16, 4, "R5 BAR0 after byte");
    wr(56, 4, 32'hFFFFFFFF, "R6 ROM probe");
    rd(56, 4, "R6 ROM");
    cmp("R6 ROM sized with enable", rd_data, 32'hFFFFF801);
    wr(56, 4, 32'h12345678, "R6 ROM even");
    rd(56, 4, "R6 ROM even readback");
    wr(48, 4, 32'hFFFFFFFF, "R6 endpoint ROM offset ignored");
    rd(48, 4, "R6 0x30 stays zero");
    wr(5, 1, 32'h00000001, "R7 cmd high byte");
    wr(3, 2, 32'h0000FF07, "R7 straddle 0x03");
    rd(0, 4, "R7 straddle readback");
    wr(4, 4, 32'h55550002, "R7 dword at cmd");
    rd(4, 4, "R7 status dropped");
    wr(6, 1, 32'h000000FF, "R7 status no strobe");
    wr(25, 1, 32'h00000007, "R8 byte 0x19");
    wr(24, 2, 32'h00000302, "R8 word 0x18");
    wr(24, 4, 32'h00090501, "R8 dword 0x18");
    rd(24, 4, "R8 bus numbers");
    step(1, 0, 8'h03, own_devfn, 0, 4, 0, "R9 wrong bus read");
    cmp("R10 miss all ones", rd_data, 32'hFFFFFFFF);
    step(1, 0, own_bus, 8'h19, 0, 2, 0, "R9 wrong function read");
    step(1, 1, own_bus, 8'h19, 64, 4, 32'h11223344, "R10 wrong function write");
    step(1, 1, 8'h07, own_devfn, 4, 2, 32'h0000FFFF, "R10 miss write no strobe");
    step(0, 0, own_bus, own_devfn, 0, 1, 0, "R11 hold after miss");
    rd(64, 4, "R10 device area intact");
    cmp("R10 device area intact", rd_data, 32'hBEEF005A);
    wr(70, 4, 32'hCAFEF00D, "R11 write holds rd");
    step(0, 0, own_bus, own_devfn, 0, 1, 0, "R11 idle");
    done = 1'b1;
    summary();
  end
endmodule